// File: doc/BRIEF.md
# Half-Duplex Collision and Retry Controller

This block decides what happens to a single frame on a shared half-duplex Ethernet segment once transmission has begun. It tracks how many bytes of the current attempt have gone out. It watches a collision input against a programmable collision window and counts the collisions the frame has suffered. It then commands one of three outcomes: jam and retry after a backoff wait, truncate the frame with a corrupted CRC (late collision), or jam and then drop the frame because too many collisions occurred. A byte strobe from the transmit datapath drives every count in the block, including the backoff wait, so the block follows the line rate.

The transmit datapath raises `frame_start_i` to begin a frame, pulses `byte_tick_i` for each byte put on the line, and raises `frame_end_i` when the last byte has gone out. The block answers with level commands (`jam_o`, `backoff_o`) and single-cycle pulses (`retry_o`, `truncate_o`, `discard_o`, `done_o`). The three `ev_*` pulses are meant to set bits in a sticky event register elsewhere. The block carries no data stream, so it has no valid/ready handshake. All inputs are plain control levels or strobes, sampled on the rising clock edge. All outputs come from registers.

Top module: `hd_retry_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no stimulus, every output is 0 and the block waits in idle.
- R2: In idle, `frame_start_i` begins an attempt: the byte position is cleared and the collision count of the frame is cleared. `frame_start_i` has no effect while a frame is in progress.
- R3: A collision during an attempt whose byte position (the number of `byte_tick_i` strobes seen since the attempt began, not counting a strobe in the collision cycle) is at most `cfg_col_window_i` raises `jam_o` from the next cycle. `jam_o` stays high for exactly 4 byte strobes.
- R4: A collision at a byte position greater than `cfg_col_window_i` produces, one cycle later, a one-cycle pulse on `truncate_o`, `ev_late_col_o` and `ev_tx_err_o`. There is no jam, the collision count is left unchanged, and the block returns to idle.
- R5: When the collision that was just jammed brings the frame's collision count above `cfg_retry_max_i`, the cycle after the last jam strobe pulses `discard_o`, `ev_retry_limit_o` and `ev_tx_err_o`, and the block returns to idle. With a maximum of 0, the first collision discards the frame.
- R6: With `cfg_no_backoff_i` set, `retry_o` pulses the cycle after the last jam strobe and the new attempt starts at once, with no `backoff_o` cycle.
- R7: Otherwise, after the n-th collision the block waits r slot times, where a slot is SLOT_BYTES byte strobes and 0 <= r < 2^min(n,10). `backoff_o` is high throughout the wait. `retry_o` pulses in the cycle that ends it (immediately after the jam when r = 0), and the new attempt starts at byte position 0.
- R8: With `cfg_alt_trunc_en_i` set, the exponent limit in R7 is `cfg_alt_trunc_exp_i` instead of 10.
- R9: `frame_end_i` during an attempt pulses `done_o` one cycle later, returns to idle and clears the collision count, so the next frame gets the full number of retries.
- R10: `collision_i` and `frame_end_i` have no effect in idle, during jam or during backoff.
- R11: If `collision_i` and `frame_end_i` arrive in the same cycle of an attempt, the collision is handled and the frame does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Begin a new frame (idle only) |
| byte_tick_i | input | 1 | One byte time elapsed on the line |
| collision_i | input | 1 | Collision seen on the medium |
| frame_end_i | input | 1 | Last byte of the frame has been sent |
| cfg_retry_max_i | input | 4 | Highest number of collisions that still allow a retry |
| cfg_col_window_i | input | 10 | Last byte position at which a collision is still normal |
| cfg_no_backoff_i | input | 1 | Retry right after the jam, without a random wait |
| cfg_alt_trunc_en_i | input | 1 | Use the programmed exponent limit |
| cfg_alt_trunc_exp_i | input | 4 | Programmed backoff exponent limit |
| jam_o | output | 1 | Send the jam pattern |
| backoff_o | output | 1 | Backoff wait in progress |
| retry_o | output | 1 | Restart the frame from its first byte |
| truncate_o | output | 1 | Cut the frame and corrupt its CRC |
| discard_o | output | 1 | Drop the frame and move on to the next one |
| done_o | output | 1 | Frame sent without a fatal collision |
| ev_late_col_o | output | 1 | Late-collision event pulse |
| ev_retry_limit_o | output | 1 | Retry-limit event pulse |
| ev_tx_err_o | output | 1 | Transmit-error event pulse |

## Verification
A wrong byte position or window compare shows up as a jam where a truncate belongs, or the reverse, one cycle after the collision. A collision count that is off or not cleared moves the discard to the wrong collision, which becomes visible right after that jam ends. A stuck or miscounted slot timer leaves `backoff_o` high for a length that is not a whole number of slots, or that exceeds 2^k-1 slots for the current exponent, and the check fires as soon as the wait goes past the bound. Any stray jam or pulse is caught in the cycle it appears, because every output is compared with the reference on every clock.

// File: rtl/hd_retry_pkg.sv
package hd_retry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_JAM     = 2'd2,
    ST_BACKOFF = 2'd3
  } hd_state_e;
endpackage

// File: rtl/hd_backoff_draw.sv
// Free-running LFSR masked down to 2^k values, k = min(collisions, limit).
module hd_backoff_draw #(
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter int EXP_W   = 4,
  parameter int WAIT_W  = 15,
  parameter int NCOL_W  = 5,
  parameter int STD_LIM = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCOL_W-1:0] ncol_i,
  input  logic              alt_en_i,
  input  logic [EXP_W-1:0]  alt_exp_i,
  output logic [WAIT_W-1:0] wait_o
);
  logic [LFSR_W-1:0] lfsr;
  logic [7:0]        lim;
  logic [7:0]        ncol8;
  logic [7:0]        k;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_W'(1);
    else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ TAPS;
    else lfsr <= lfsr >> 1;
  end

  always_comb begin
    lim   = alt_en_i ? 8'(alt_exp_i) : 8'(STD_LIM);
    ncol8 = 8'(ncol_i);
    k     = (ncol8 < lim) ? ncol8 : lim;
  end

  for (genvar i = 0; i < WAIT_W; i++) begin : g_mask
    assign wait_o[i] = lfsr[i] & (8'(i) < k);
  end

  // R7: a stuck all-zero LFSR would freeze every backoff at zero slots
  p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: rtl/hd_slot_timer.sv
// Counts slot times in byte strobes; last_o marks the final strobe of the wait.
module hd_slot_timer #(
  parameter int SLOT_BYTES = 64,
  parameter int WAIT_W     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] slots_i,
  input  logic              tick_i,
  output logic              active_o,
  output logic              last_o
);
  localparam int SB_W = $clog2(SLOT_BYTES + 1);
  localparam logic [SB_W-1:0] SB_LAST = SB_W'(SLOT_BYTES - 1);

  logic [SB_W-1:0]   slot_byte;
  logic [WAIT_W-1:0] slots_left;

  assign last_o = active_o && tick_i && (slot_byte == SB_LAST) &&
                  (slots_left == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_byte  <= '0;
      slots_left <= '0;
      active_o   <= 1'b0;
    end else if (load_i) begin
      slot_byte  <= '0;
      slots_left <= slots_i;
      active_o   <= (slots_i != '0);
    end else if (active_o && tick_i) begin
      if (slot_byte == SB_LAST) begin
        slot_byte  <= '0;
        slots_left <= slots_left - WAIT_W'(1);
        if (slots_left == WAIT_W'(1)) active_o <= 1'b0;
      end else begin
        slot_byte <= slot_byte + SB_W'(1);
      end
    end
  end

  p_load_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !active_o);
  p_load_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (slots_i != '0));
endmodule

// File: rtl/hd_retry_ctrl.sv
module hd_retry_ctrl #(
  parameter int RMAX_W     = 4,
  parameter int WIN_W      = 10,
  parameter int EXP_W      = 4,
  parameter int JAM_BYTES  = 4,
  parameter int SLOT_BYTES = 64,
  parameter int STD_LIM    = 10,
  parameter int LFSR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              byte_tick_i,
  input  logic              collision_i,
  input  logic              frame_end_i,
  input  logic [RMAX_W-1:0] cfg_retry_max_i,
  input  logic [WIN_W-1:0]  cfg_col_window_i,
  input  logic              cfg_no_backoff_i,
  input  logic              cfg_alt_trunc_en_i,
  input  logic [EXP_W-1:0]  cfg_alt_trunc_exp_i,
  output logic              jam_o,
  output logic              backoff_o,
  output logic              retry_o,
  output logic              truncate_o,
  output logic              discard_o,
  output logic              done_o,
  output logic              ev_late_col_o,
  output logic              ev_retry_limit_o,
  output logic              ev_tx_err_o
);
  import hd_retry_pkg::*;

  localparam int CNT_W  = WIN_W + 1;
  localparam int NCOL_W = RMAX_W + 1;
  localparam int WAIT_W = 2**EXP_W - 1;
  localparam int JCNT_W = $clog2(JAM_BYTES + 1);
  localparam logic [JCNT_W-1:0] JAM_LAST = JCNT_W'(JAM_BYTES - 1);

  hd_state_e         state;
  logic [CNT_W-1:0]  byte_pos;
  logic [NCOL_W-1:0] ncol;
  logic [JCNT_W-1:0] jam_cnt;
  logic [WAIT_W-1:0] wait_slots;
  logic              jam_end, over_limit, late, tmr_load, tmr_active, tmr_last;

  assign late       = byte_pos > {1'b0, cfg_col_window_i};
  assign over_limit = ncol > NCOL_W'(cfg_retry_max_i);
  assign jam_end    = (state == ST_JAM) && byte_tick_i && (jam_cnt == JAM_LAST);
  assign tmr_load   = jam_end && !over_limit && !cfg_no_backoff_i &&
                      (wait_slots != '0);
  assign jam_o      = (state == ST_JAM);
  assign backoff_o  = (state == ST_BACKOFF);

  hd_backoff_draw #(
    .LFSR_W (LFSR_W), .EXP_W(EXP_W), .WAIT_W(WAIT_W),
    .NCOL_W (NCOL_W), .STD_LIM(STD_LIM)
  ) u_draw (
    .clk      (clk),
    .rst_n    (rst_n),
    .ncol_i   (ncol),
    .alt_en_i (cfg_alt_trunc_en_i),
    .alt_exp_i(cfg_alt_trunc_exp_i),
    .wait_o   (wait_slots)
  );

  hd_slot_timer #(.SLOT_BYTES(SLOT_BYTES), .WAIT_W(WAIT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (tmr_load),
    .slots_i (wait_slots),
    .tick_i  (byte_tick_i),
    .active_o(tmr_active),
    .last_o  (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state            <= ST_IDLE;
      byte_pos         <= '0;
      ncol             <= '0;
      jam_cnt          <= '0;
      retry_o          <= 1'b0;
      truncate_o       <= 1'b0;
      discard_o        <= 1'b0;
      done_o           <= 1'b0;
      ev_late_col_o    <= 1'b0;
      ev_retry_limit_o <= 1'b0;
      ev_tx_err_o      <= 1'b0;
    end else begin
      retry_o          <= 1'b0;
      truncate_o       <= 1'b0;
      discard_o        <= 1'b0;
      done_o           <= 1'b0;
      ev_late_col_o    <= 1'b0;
      ev_retry_limit_o <= 1'b0;
      ev_tx_err_o      <= 1'b0;
      unique case (state)
        ST_IDLE: if (frame_start_i) begin
          state    <= ST_TX;
          byte_pos <= '0;
          ncol     <= '0;
        end
        ST_TX: begin
          if (collision_i) begin
            if (late) begin
              truncate_o    <= 1'b1;
              ev_late_col_o <= 1'b1;
              ev_tx_err_o   <= 1'b1;
              state         <= ST_IDLE;
            end else begin
              ncol    <= ncol + NCOL_W'(1);
              jam_cnt <= '0;
              state   <= ST_JAM;
            end
          end else if (frame_end_i) begin
            done_o <= 1'b1;
            ncol   <= '0;
            state  <= ST_IDLE;
          end else if (byte_tick_i && (byte_pos != '1)) begin
            byte_pos <= byte_pos + CNT_W'(1);
          end
        end
        ST_JAM: begin
          if (jam_end) begin
            if (over_limit) begin
              discard_o        <= 1'b1;
              ev_retry_limit_o <= 1'b1;
              ev_tx_err_o      <= 1'b1;
              state            <= ST_IDLE;
            end else if (tmr_load) begin
              state <= ST_BACKOFF;
            end else begin
              retry_o  <= 1'b1;
              byte_pos <= '0;
              state    <= ST_TX;
            end
          end else if (byte_tick_i) begin
            jam_cnt <= jam_cnt + JCNT_W'(1);
          end
        end
        ST_BACKOFF: if (tmr_last) begin
          retry_o  <= 1'b1;
          byte_pos <= '0;
          state    <= ST_TX;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_late_from_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_late_col_o |-> $past(collision_i));
  p_jam_from_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_o) |-> $past(collision_i));
  p_discard_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |-> ($past(ncol) > NCOL_W'($past(cfg_retry_max_i))));
  p_retry_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> $past(jam_o || backoff_o));
  p_backoff_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_o == tmr_active);
endmodule

// File: tb/hd_retry_ctrl_tb.sv
module hd_retry_ctrl_tb;
  localparam int SLOT = 2;
  localparam int JAM  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, byt = 1'b0, col = 1'b0, eof = 1'b0;
  logic [3:0] c_max = 4'd15;
  logic [9:0] c_win = 10'd55;
  logic c_nb = 1'b0, c_alt = 1'b0;
  logic [3:0] c_altx = 4'd10;
  logic jam_o, backoff_o, retry_o, truncate_o, discard_o, done_o;
  logic ev_late_col_o, ev_retry_limit_o, ev_tx_err_o;

  always #4 clk = ~clk;

  hd_retry_ctrl #(.SLOT_BYTES(SLOT), .JAM_BYTES(JAM)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(sof), .byte_tick_i(byt), .collision_i(col), .frame_end_i(eof),
    .cfg_retry_max_i(c_max), .cfg_col_window_i(c_win), .cfg_no_backoff_i(c_nb),
    .cfg_alt_trunc_en_i(c_alt), .cfg_alt_trunc_exp_i(c_altx),
    .jam_o(jam_o), .backoff_o(backoff_o), .retry_o(retry_o), .truncate_o(truncate_o),
    .discard_o(discard_o), .done_o(done_o), .ev_late_col_o(ev_late_col_o),
    .ev_retry_limit_o(ev_retry_limit_o), .ev_tx_err_o(ev_tx_err_o)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  // reference model: 0 idle, 1 sending, 2 jamming, 3 waiting
  int m_st = 0, m_bcnt = 0, m_ncol = 0, m_jcnt = 0, m_bo = 0;
  bit e_retry, e_trunc, e_disc, e_done, e_late, e_crl, e_err;

  task automatic chk(string req, string name, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  function automatic int exp_k();
    int lim = c_alt ? int'(c_altx) : 10;
    return (m_ncol < lim) ? m_ncol : lim;
  endfunction

  task automatic compare();
    int maxb;
    if (m_st == 3) begin
      maxb = ((1 << exp_k()) - 1) * SLOT;  // R7 and R8 bound
      if (retry_o === 1'b1 && backoff_o === 1'b0) begin
        n_cmp++;
        if ((m_bo % SLOT) != 0 || m_bo > maxb) begin
          n_bad++;
          $display("FAIL R7/R8 backoff bytes actual=%0d expected=multiple of %0d up to %0d",
                   m_bo, SLOT, maxb);
        end
        m_st = 1; m_bcnt = 0; e_retry = 1'b1;
      end else if (m_bo > maxb) begin
        n_cmp++; n_bad++;
        $display("FAIL R7/R8 backoff bytes actual=%0d expected=at most %0d", m_bo, maxb);
      end
    end
    chk("R3", "jam_o", jam_o, m_st == 2);
    chk("R7", "backoff_o", backoff_o, m_st == 3);
    chk("R6/R7", "retry_o", retry_o, e_retry);
    chk("R4", "truncate_o", truncate_o, e_trunc);
    chk("R4", "ev_late_col_o", ev_late_col_o, e_late);
    chk("R5", "discard_o", discard_o, e_disc);
    chk("R5", "ev_retry_limit_o", ev_retry_limit_o, e_crl);
    chk("R4/R5", "ev_tx_err_o", ev_tx_err_o, e_err);
    chk("R9", "done_o", done_o, e_done);
  endtask

  task automatic advance(bit s, bit b, bit c, bit e);
    {e_retry, e_trunc, e_disc, e_done, e_late, e_crl, e_err} = '0;
    case (m_st)
      0: if (s) begin m_st = 1; m_bcnt = 0; m_ncol = 0; end
      1: if (c) begin
           if (m_bcnt > int'(c_win)) begin
             e_trunc = 1; e_late = 1; e_err = 1; m_st = 0;
           end else begin
             m_ncol++; m_jcnt = 0; m_st = 2;
           end
         end else if (e) begin
           e_done = 1; m_ncol = 0; m_st = 0;
         end else if (b && m_bcnt < 2047) m_bcnt++;
      2: if (b) begin
           m_jcnt++;
           if (m_jcnt == JAM) begin
             if (m_ncol > int'(c_max)) begin
               e_disc = 1; e_crl = 1; e_err = 1; m_st = 0;
             end else if (c_nb) begin
               e_retry = 1; m_bcnt = 0; m_st = 1;
             end else begin
               m_bo = 0; m_st = 3;
             end
           end
         end
      default: if (b) m_bo++;
    endcase
  endtask

  task automatic step(bit s, bit b, bit c, bit e);
    @(negedge clk);
    compare();
    sof = s; byt = b; col = c; eof = e;
    advance(s, b, c, e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic send(int n, bit gap);
    for (int i = 0; i < n; i++) begin
      step(0, 1, 0, 0);
      if (gap) step(0, 0, 0, 0);
    end
  endtask

  // R10: collision and frame end held on the first jam cycle are ignored
  task automatic finish_jam();
    int g = 0;
    while (m_st == 2 && g < 100) begin
      step(0, (g % 3) != 1, g == 0, g == 0);
      g++;
    end
  endtask

  // R10: a collision inside the wait is ignored
  task automatic wait_bo();
    int g = 0;
    while (m_st == 3 && g < 20000) begin
      step(0, 1, g == 1, 1'b0);
      g++;
    end
  endtask

  task automatic collide_and_recover(int pre);
    send(pre, 1'b0);
    step(0, 0, 1, 0);
    finish_jam();
    wait_bo();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: outputs quiet while in reset
    repeat (3) @(negedge clk);
    chk("R1", "jam_o", jam_o, 1'b0);
    chk("R1", "backoff_o", backoff_o, 1'b0);
    chk("R1", "retry_o", retry_o, 1'b0);
    chk("R1", "ev_tx_err_o", ev_tx_err_o, 1'b0);
    rst_n = 1'b1;
    idle(3);

    // R10 in idle, R2 start and ignored restart, R9 completion
    step(0, 0, 1, 0); step(0, 0, 0, 1);
    step(1, 0, 0, 0); send(20, 1'b0);
    step(1, 1, 0, 0); send(3, 1'b1);
    step(0, 0, 0, 1); idle(2);

    // R3 jam length and R6 immediate retry
    c_nb = 1'b1;
    step(1, 0, 0, 0); send(10, 1'b0); step(0, 0, 1, 0);
    finish_jam(); send(30, 1'b1); step(0, 0, 0, 1); idle(2);

    // R4: byte position equal to the window is normal, one above is late
    c_win = 10'd5;
    step(1, 0, 0, 0); send(5, 1'b0); step(0, 0, 1, 0); finish_jam();
    send(6, 1'b0); step(0, 1, 1, 0); idle(2);
    c_win = 10'd55;

    // R5: limit of 2, limit of 0, limit of 15
    c_max = 4'd2;
    step(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) collide_and_recover(2);
    idle(2);
    c_max = 4'd0;
    step(1, 0, 0, 0); collide_and_recover(1); idle(2);
    c_max = 4'd15;
    step(1, 0, 0, 0);
    for (int i = 0; i < 16; i++) collide_and_recover(1);
    idle(2);

    // R9: collision count restarts for each frame
    c_max = 4'd1;
    step(1, 0, 0, 0); collide_and_recover(2); send(2, 1'b0); step(0, 0, 0, 1);
    step(1, 0, 0, 0); collide_and_recover(2); send(2, 1'b0); step(0, 0, 0, 1);
    idle(2);
    c_max = 4'd15;

    // R7: random backoff with standard exponent limit
    c_nb = 1'b0;
    step(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) collide_and_recover(3);
    send(4, 1'b1); step(0, 0, 0, 1); idle(2);

    // R8: programmed exponent limits 2 and 0
    c_alt = 1'b1; c_altx = 4'd2;
    step(1, 0, 0, 0);
    for (int i = 0; i < 8; i++) collide_and_recover(2);
    step(0, 0, 0, 1); idle(2);
    c_altx = 4'd0;
    step(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) collide_and_recover(1);
    step(0, 0, 0, 1); idle(2);
    c_alt = 1'b0; c_altx = 4'd10;

    // R11: collision and frame end together
    c_nb = 1'b1;
    step(1, 0, 0, 0); send(3, 1'b0); step(0, 1, 1, 1);
    finish_jam(); send(2, 1'b0); step(0, 0, 0, 1);
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule